// File: doc/BRIEF.md
# Emulated PCI-to-PCI Bridge Configuration Header

This block stands in for the type-1 configuration header of a root port that has no bridge silicon behind it. Configuration software reads and writes it exactly as it would a real bridge: reads are dword-decoded and the selected byte or halfword is shifted down to bit 0. Writes may be byte, halfword or word wide, and a narrow write is folded into the current dword before it is stored. Fields the block does not implement read as zero. Offsets it does not know read as all ones and flag an error.

Besides the header, the block turns its stored base/limit registers into ready-to-use address windows for downstream decode logic. A memory window and an I/O window each carry a valid flag, a base and a size. Each window also has a one-cycle change strobe, so the window programmer knows when to reload. The secondary bus number is exported together with an update strobe. A build parameter removes I/O support: the I/O enable bit is then forced low and the I/O base/limit byte pair is hidden.

Accesses are sequenced by a four-state controller. `ST_IDLE` accepts a request: a read takes priority and moves to `ST_RD_RESP`; a write moves to `ST_WR_MERGE`. `ST_RD_RESP` returns data with `cfg_ack` and goes back to `ST_IDLE`. `ST_WR_MERGE` fetches the current dword, merges the new lanes and goes to `ST_WR_COMMIT`. `ST_WR_COMMIT` stores the merged dword (unless it is in error), raises `cfg_ack` and goes back to `ST_IDLE`. A request that arrives outside `ST_IDLE` is ignored.

Top module: `p2p_hdr_emu`

## Requirements
- R1: After reset, dword 0x08 reads {16'h0604, 8'h00, hw_rev[7:0]} and dword 0x0C reads 32'h0001_0010 (header type 1, cache line 0x10). The command dword reads 0 and both windows are invalid. Writes to 0x08 and 0x0C are ignored.
- R2: Dword 0x00 reads {hw_ident[31:16], VENDOR_ID}.
- R3: The low byte of both the I/O base and the I/O limit always has bit 0 set (32-bit I/O range code 1), whatever was written. The upper half of dword 0x1C (secondary status) reads zero.
- R4: Dwords 0x24, 0x38 and 0x3C read zero without error. Any other offset outside {0x00-0x20, 0x30} (for example 0x28, 0x34, 0x40, 0x100) reads 32'hFFFF_FFFF with cfg_err set.
- R5: cfg_size encodes 0 = byte, 1 = halfword, 2 = word. A narrow write replaces only the addressed lane (lane = cfg_addr[1:0]) with the low bits of cfg_wdata. A narrow read returns the addressed lane shifted to bit 0, with the upper bits zero.
- R6: With HAS_IO = 0, bit 0 of every command write is stored as 0. Dword 0x1C then reads zero in its low half. The I/O window never becomes valid and never strobes.
- R7: The memory window is valid when memlimit >= membase (16-bit compare) and command bit 1 is set. Its base is {membase[15:4], 20'h0}. Its size is {memlimit[15:4], 20'hFFFFF} - base + 1 (33 bits). When invalid, base and size are zero.
- R8: The I/O window is valid when iolimit >= iobase, limit-upper >= base-upper and command bit 0 is set. Its base is {base_upper16, iobase[7:4], 12'h0}. Its size is {limit_upper16, iolimit[7:4], 12'hFFF} - base + 1. When invalid, base and size are zero.
- R9: A write to dword 0x18 stores the primary, secondary, subordinate and secondary-latency bytes (bits 7:0 to 31:24). It raises sec_bus_upd in the cycle of cfg_ack, with sec_bus_num holding the secondary byte.
- R10: mem_win_chg pulses with cfg_ack after a write to 0x20, or after a command write that flips bit 1. io_win_chg pulses after a write to 0x1C or 0x30, or after a command write that flips bit 0. Both strobes can pulse in the same cycle.
- R11: A read raises cfg_ack (with cfg_rdata) on the second rising edge after the request is sampled. A write raises cfg_ack on the third. cfg_ack lasts one cycle.
- R12: A write or read with cfg_size = 3 is rejected: cfg_err is set with cfg_ack and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd | input | 1 | Read request (one cycle) |
| cfg_wr | input | 1 | Write request (one cycle) |
| cfg_addr | input | ADDR_W | Byte offset into configuration space |
| cfg_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| cfg_wdata | input | 32 | Write data, right-aligned |
| cfg_rdata | output | 32 | Read data, right-aligned |
| cfg_ack | output | 1 | Access complete |
| cfg_err | output | 1 | Access rejected (with cfg_ack) |
| hw_ident | input | 32 | Identity word; upper half is the device ID |
| hw_rev | input | 32 | Revision word; low byte is the revision |
| mem_win_valid | output | 1 | Memory window enabled and well formed |
| mem_win_base | output | 32 | Memory window base |
| mem_win_size | output | 33 | Memory window size in bytes |
| mem_win_chg | output | 1 | Memory window reprogram strobe |
| io_win_valid | output | 1 | I/O window enabled and well formed |
| io_win_base | output | 32 | I/O window base |
| io_win_size | output | 33 | I/O window size in bytes |
| io_win_chg | output | 1 | I/O window reprogram strobe |
| sec_bus_num | output | 8 | Secondary bus number |
| sec_bus_upd | output | 1 | Secondary bus update strobe |

## Verification
The two window-change strobes can land in the same cycle. This happens when one command write flips both the I/O and the memory enable bits. The bench provokes it by writing 0x0000 over a command value of 0x0003. It then expects both strobes high beside cfg_ack, and both windows invalid from that cycle on. A following write of the same command value must raise neither strobe. The bench also checks the reverse case: a command write that flips only one enable must leave the other strobe low.

// File: rtl/p2p_hdr_pkg.sv
package p2p_hdr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RD_RESP   = 2'd1,
        ST_WR_MERGE  = 2'd2,
        ST_WR_COMMIT = 2'd3
    } hdr_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

    // dword indices (byte offset >> 2); positions fixed by the header layout
    localparam logic [5:0] DW_IDENT  = 6'h00;
    localparam logic [5:0] DW_CMD    = 6'h01;
    localparam logic [5:0] DW_CLASS  = 6'h02;
    localparam logic [5:0] DW_MISC   = 6'h03;
    localparam logic [5:0] DW_BAR0   = 6'h04;
    localparam logic [5:0] DW_BAR1   = 6'h05;
    localparam logic [5:0] DW_BUSNUM = 6'h06;
    localparam logic [5:0] DW_IOLO   = 6'h07;
    localparam logic [5:0] DW_MEMWIN = 6'h08;
    localparam logic [5:0] DW_PREF   = 6'h09;
    localparam logic [5:0] DW_IOHI   = 6'h0C;
    localparam logic [5:0] DW_ROM    = 6'h0E;
    localparam logic [5:0] DW_IRQ    = 6'h0F;

    localparam logic [15:0] CLASS_BRIDGE = 16'h0604;
    localparam logic [7:0]  HDR_BRIDGE   = 8'h01;
    localparam logic [7:0]  CLS_RESET    = 8'h10;
    localparam logic [7:0]  IO_TYPE32    = 8'h01;

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/p2p_hdr_ctrl.sv
module p2p_hdr_ctrl
    import p2p_hdr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rd,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        cfg_size,
    input  logic [31:0]       cfg_wdata,
    input  logic [31:0]       rd_dword,
    input  logic              rd_hit,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wr_en,
    output logic [31:0]       wr_data,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_ack,
    output logic              cfg_err
);

    hdr_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic [31:0]       wdata_q;
    logic [31:0]       merged_q;
    logic              err_q;
    logic [4:0]        shift;
    logic [31:0]       lane_m;
    logic [31:0]       extract;

    always_comb begin
        shift   = (size_q == SZ_WORD) ? 5'd0 : {addr_q[1:0], 3'b000};
        lane_m  = size_mask(size_q) << shift;
        extract = (rd_dword >> shift) & size_mask(size_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_rd)      state_d = ST_RD_RESP;
                else if (cfg_wr) state_d = ST_WR_MERGE;
            end
            ST_RD_RESP:   state_d = ST_IDLE;
            ST_WR_MERGE:  state_d = ST_WR_COMMIT;
            ST_WR_COMMIT: state_d = ST_IDLE;
        endcase
    end

    // outputs and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            size_q    <= SZ_WORD;
            wdata_q   <= '0;
            merged_q  <= '0;
            err_q     <= 1'b0;
            cfg_rdata <= '0;
            cfg_ack   <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            cfg_ack <= 1'b0;
            cfg_err <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cfg_rd || cfg_wr) begin
                        addr_q  <= cfg_addr;
                        size_q  <= cfg_size;
                        wdata_q <= cfg_wdata;
                    end
                end
                ST_RD_RESP: begin
                    cfg_ack <= 1'b1;
                    if (!rd_hit || size_q == SZ_BAD) begin
                        cfg_rdata <= 32'hFFFF_FFFF;
                        cfg_err   <= 1'b1;
                    end else begin
                        cfg_rdata <= extract;
                    end
                end
                ST_WR_MERGE: begin
                    err_q    <= !rd_hit || (size_q == SZ_BAD);
                    merged_q <= (rd_dword & ~lane_m)
                              | ((wdata_q & size_mask(size_q)) << shift);
                end
                ST_WR_COMMIT: begin
                    cfg_ack <= 1'b1;
                    cfg_err <= err_q;
                end
            endcase
        end
    end

    assign acc_addr = addr_q;
    assign wr_en    = (state_q == ST_WR_COMMIT) && !err_q;
    assign wr_data  = merged_q;

    a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cfg_rd) |=> ##1 cfg_ack);

    a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |=> !cfg_ack);

    a_r12_bad_size_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cfg_rd && cfg_wr && cfg_size == SZ_BAD)
        |=> ##1 !wr_en ##1 (cfg_ack && cfg_err));

endmodule

// File: rtl/p2p_hdr_regs.sv
module p2p_hdr_regs
    import p2p_hdr_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [15:0] VENDOR_ID = 16'hC0DE,
    parameter bit          HAS_IO    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       hw_ident,
    input  logic [31:0]       hw_rev,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_dword,
    output logic              rd_hit,
    output logic [15:0]       cmd_q,
    output logic [15:0]       membase_q,
    output logic [15:0]       memlimit_q,
    output logic [7:0]        iobase_q,
    output logic [7:0]        iolimit_q,
    output logic [15:0]       iobase_up_q,
    output logic [15:0]       iolimit_up_q,
    output logic [7:0]        sec_bus_q,
    output logic              sec_bus_upd,
    output logic              mem_chg,
    output logic              io_chg
);

    logic [31:0] bar0_q, bar1_q;
    logic [7:0]  pri_q, sub_q, slat_q;
    logic [5:0]  dw;
    logic        in_rng;
    logic [15:0] cmd_new;
    logic        unused_bits;

    assign unused_bits = ^{hw_ident[15:0], hw_rev[31:8]};
    assign dw          = acc_addr[7:2];
    assign in_rng      = (acc_addr >> 8) == '0;

    always_comb begin
        cmd_new = wr_data[15:0];
        if (!HAS_IO) cmd_new[0] = 1'b0;
    end

    always_comb begin
        rd_hit   = in_rng;
        rd_dword = 32'hFFFF_FFFF;
        if (in_rng) begin
            case (dw)
                DW_IDENT:  rd_dword = {hw_ident[31:16], VENDOR_ID};
                DW_CMD:    rd_dword = {16'h0000, cmd_q};
                DW_CLASS:  rd_dword = {CLASS_BRIDGE, 8'h00, hw_rev[7:0]};
                DW_MISC:   rd_dword = {8'h00, HDR_BRIDGE, 8'h00, CLS_RESET};
                DW_BAR0:   rd_dword = bar0_q;
                DW_BAR1:   rd_dword = bar1_q;
                DW_BUSNUM: rd_dword = {slat_q, sub_q, sec_bus_q, pri_q};
                DW_IOLO:   rd_dword = HAS_IO ? {16'h0000, iolimit_q, iobase_q} : 32'h0;
                DW_MEMWIN: rd_dword = {memlimit_q, membase_q};
                DW_PREF:   rd_dword = 32'h0;
                DW_IOHI:   rd_dword = {iolimit_up_q, iobase_up_q};
                DW_ROM:    rd_dword = 32'h0;
                DW_IRQ:    rd_dword = 32'h0;
                default:   rd_hit   = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q        <= '0;
            bar0_q       <= '0;
            bar1_q       <= '0;
            pri_q        <= '0;
            sec_bus_q    <= '0;
            sub_q        <= '0;
            slat_q       <= '0;
            iobase_q     <= IO_TYPE32;
            iolimit_q    <= IO_TYPE32;
            membase_q    <= '0;
            memlimit_q   <= '0;
            iobase_up_q  <= '0;
            iolimit_up_q <= '0;
            sec_bus_upd  <= 1'b0;
            mem_chg      <= 1'b0;
            io_chg       <= 1'b0;
        end else begin
            sec_bus_upd <= 1'b0;
            mem_chg     <= 1'b0;
            io_chg      <= 1'b0;
            if (wr_en) begin
                case (dw)
                    DW_CMD: begin
                        cmd_q   <= cmd_new;
                        mem_chg <= cmd_new[1] ^ cmd_q[1];
                        io_chg  <= cmd_new[0] ^ cmd_q[0];
                    end
                    DW_BAR0: bar0_q <= wr_data;
                    DW_BAR1: bar1_q <= wr_data;
                    DW_BUSNUM: begin
                        pri_q       <= wr_data[7:0];
                        sec_bus_q   <= wr_data[15:8];
                        sub_q       <= wr_data[23:16];
                        slat_q      <= wr_data[31:24];
                        sec_bus_upd <= 1'b1;
                    end
                    DW_IOLO: begin
                        iobase_q  <= wr_data[7:0]  | IO_TYPE32;
                        iolimit_q <= wr_data[15:8] | IO_TYPE32;
                        io_chg    <= 1'(HAS_IO);
                    end
                    DW_MEMWIN: begin
                        membase_q  <= wr_data[15:0];
                        memlimit_q <= wr_data[31:16];
                        mem_chg    <= 1'b1;
                    end
                    DW_IOHI: begin
                        iobase_up_q  <= wr_data[15:0];
                        iolimit_up_q <= wr_data[31:16];
                        io_chg       <= 1'(HAS_IO);
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r9_bus_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_upd |=> !sec_bus_upd);

    a_r10_mem_chg_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_chg |=> !mem_chg);

    a_r10_io_chg_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        io_chg |=> !io_chg);

endmodule

// File: rtl/p2p_hdr_win.sv
module p2p_hdr_win #(
    parameter bit IS_IO = 1'b0
) (
    input  logic [15:0] base_lo,
    input  logic [15:0] lim_lo,
    input  logic [15:0] base_hi,
    input  logic [15:0] lim_hi,
    input  logic        enable,
    output logic        valid,
    output logic [31:0] base,
    output logic [32:0] size
);

    logic [31:0] b_raw, l_raw;
    logic        ordered;

    generate
        if (IS_IO) begin : g_io
            assign b_raw = {base_hi, base_lo[7:4], 12'h000};
            assign l_raw = {lim_hi,  lim_lo[7:4],  12'hFFF};
        end else begin : g_mem
            assign b_raw = {base_lo[15:4], 20'h00000};
            assign l_raw = {lim_lo[15:4],  20'hFFFFF};
        end
    endgenerate

    assign ordered = !(lim_lo < base_lo) && !(lim_hi < base_hi);
    assign valid   = ordered && enable;
    assign base    = valid ? b_raw : 32'h0;
    assign size    = valid ? ({1'b0, l_raw} - {1'b0, b_raw} + 33'd1) : 33'd0;

    generate
        if (IS_IO) begin : g_io_chk
            always_comb begin
                if (valid) begin
                    a_r8_io_granule: assert (size >= 33'h1000 && base[11:0] == 12'h000);
                end
            end
        end else begin : g_mem_chk
            always_comb begin
                if (valid) begin
                    a_r7_mem_granule: assert (size >= 33'h10_0000 && base[19:0] == 20'h0);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/p2p_hdr_emu.sv
module p2p_hdr_emu
    import p2p_hdr_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [15:0] VENDOR_ID = 16'hC0DE,
    parameter bit          HAS_IO    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rd,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        cfg_size,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_ack,
    output logic              cfg_err,
    input  logic [31:0]       hw_ident,
    input  logic [31:0]       hw_rev,
    output logic              mem_win_valid,
    output logic [31:0]       mem_win_base,
    output logic [32:0]       mem_win_size,
    output logic              mem_win_chg,
    output logic              io_win_valid,
    output logic [31:0]       io_win_base,
    output logic [32:0]       io_win_size,
    output logic              io_win_chg,
    output logic [7:0]        sec_bus_num,
    output logic              sec_bus_upd
);

    logic [ADDR_W-1:0] acc_addr;
    logic              wr_en;
    logic [31:0]       wr_data;
    logic [31:0]       rd_dword;
    logic              rd_hit;
    logic [15:0]       cmd_q, membase_q, memlimit_q, iobase_up_q, iolimit_up_q;
    logic [7:0]        iobase_q, iolimit_q;

    p2p_hdr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_rd    (cfg_rd),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_size  (cfg_size),
        .cfg_wdata (cfg_wdata),
        .rd_dword  (rd_dword),
        .rd_hit    (rd_hit),
        .acc_addr  (acc_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cfg_rdata (cfg_rdata),
        .cfg_ack   (cfg_ack),
        .cfg_err   (cfg_err)
    );

    p2p_hdr_regs #(.ADDR_W(ADDR_W), .VENDOR_ID(VENDOR_ID), .HAS_IO(HAS_IO)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_addr     (acc_addr),
        .hw_ident     (hw_ident),
        .hw_rev       (hw_rev),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_dword     (rd_dword),
        .rd_hit       (rd_hit),
        .cmd_q        (cmd_q),
        .membase_q    (membase_q),
        .memlimit_q   (memlimit_q),
        .iobase_q     (iobase_q),
        .iolimit_q    (iolimit_q),
        .iobase_up_q  (iobase_up_q),
        .iolimit_up_q (iolimit_up_q),
        .sec_bus_q    (sec_bus_num),
        .sec_bus_upd  (sec_bus_upd),
        .mem_chg      (mem_win_chg),
        .io_chg       (io_win_chg)
    );

    p2p_hdr_win #(.IS_IO(1'b0)) u_mem_win (
        .base_lo (membase_q),
        .lim_lo  (memlimit_q),
        .base_hi (16'h0000),
        .lim_hi  (16'h0000),
        .enable  (cmd_q[1]),
        .valid   (mem_win_valid),
        .base    (mem_win_base),
        .size    (mem_win_size)
    );

    p2p_hdr_win #(.IS_IO(1'b1)) u_io_win (
        .base_lo ({8'h00, iobase_q}),
        .lim_lo  ({8'h00, iolimit_q}),
        .base_hi (iobase_up_q),
        .lim_hi  (iolimit_up_q),
        .enable  (cmd_q[0]),
        .valid   (io_win_valid),
        .base    (io_win_base),
        .size    (io_win_size)
    );

    a_r9_bus_upd_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_upd |-> (cfg_ack && !cfg_err));

    a_r10_chg_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_win_chg || io_win_chg) |-> (cfg_ack && !cfg_err));

    generate
        if (!HAS_IO) begin : g_noio_chk
            a_r6_io_never_live: assert property (@(posedge clk) disable iff (!rst_n)
                !io_win_valid && !io_win_chg);
        end
    endgenerate

endmodule

// File: tb/p2p_hdr_emu_bench.sv
module p2p_hdr_emu_bench;

    localparam int AW = 12;
    localparam logic [15:0] VID = 16'hC0DE;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          cfg_rd, cfg_wr;
    logic [AW-1:0] cfg_addr;
    logic [1:0]    cfg_size;
    logic [31:0]   cfg_wdata;
    logic [31:0]   hw_ident, hw_rev;

    logic [31:0] rdata_a, rdata_b;
    logic        ack_a, ack_b, err_a, err_b;
    logic        mv_a, mv_b, mc_a, mc_b, iv_a, iv_b, ic_a, ic_b, bu_a, bu_b;
    logic [31:0] mb_a, mb_b, ib_a, ib_b;
    logic [32:0] ms_a, ms_b, is_a, is_b;
    logic [7:0]  sb_a, sb_b;

    p2p_hdr_emu #(.ADDR_W(AW), .VENDOR_ID(VID), .HAS_IO(1'b1)) u_p2p_hdr_emu (
        .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata_a), .cfg_ack(ack_a), .cfg_err(err_a),
        .hw_ident(hw_ident), .hw_rev(hw_rev),
        .mem_win_valid(mv_a), .mem_win_base(mb_a), .mem_win_size(ms_a), .mem_win_chg(mc_a),
        .io_win_valid(iv_a), .io_win_base(ib_a), .io_win_size(is_a), .io_win_chg(ic_a),
        .sec_bus_num(sb_a), .sec_bus_upd(bu_a)
    );

    p2p_hdr_emu #(.ADDR_W(AW), .VENDOR_ID(VID), .HAS_IO(1'b0)) u_p2p_hdr_emu_noio (
        .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata_b), .cfg_ack(ack_b), .cfg_err(err_b),
        .hw_ident(hw_ident), .hw_rev(hw_rev),
        .mem_win_valid(mv_b), .mem_win_base(mb_b), .mem_win_size(ms_b), .mem_win_chg(mc_b),
        .io_win_valid(iv_b), .io_win_base(ib_b), .io_win_size(is_b), .io_win_chg(ic_b),
        .sec_bus_num(sb_b), .sec_bus_upd(bu_b)
    );

    int checks = 0;
    int fails  = 0;

    // values captured in the ack cycle
    logic [31:0] r_a, r_b;
    logic        e_a, c_mem, c_io, c_bus, c_io_b;
    int          lat;

    task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit is_wr, input logic [AW-1:0] a, input logic [1:0] s,
                          input logic [31:0] d);
        @(negedge clk);
        cfg_rd = !is_wr; cfg_wr = is_wr; cfg_addr = a; cfg_size = s; cfg_wdata = d;
        @(negedge clk);
        cfg_rd = 1'b0; cfg_wr = 1'b0;
        lat = 1;
        while (!ack_a && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        r_a = rdata_a; r_b = rdata_b; e_a = err_a;
        c_mem = mc_a; c_io = ic_a; c_bus = bu_a; c_io_b = ic_b;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [1:0] s);
        access(1'b0, a, s, 32'h0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [1:0] s, input logic [31:0] d);
        access(1'b1, a, s, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog actual=hung expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] bar;
        logic [7:0]  blist [3];
        logic [7:0]  llist [3];
        logic [15:0] ulist [2];
        logic [15:0] mlist [4];
        blist = '{8'h00, 8'h10, 8'hF0};
        llist = '{8'h00, 8'h20, 8'hF0};
        ulist = '{16'h0000, 16'h0001};
        mlist = '{16'h0000, 16'h0010, 16'h8000, 16'hFFF0};

        rst_n = 1'b0; cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_addr = '0;
        cfg_size = 2'd2; cfg_wdata = '0;
        hw_ident = 32'hBEEF_0123; hw_rev = 32'h1234_56A5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ack idle", {32'h0, ack_a}, 33'd0);
        chk("R1 mem win invalid", {32'h0, mv_a}, 33'd0);
        chk("R1 io win invalid", {32'h0, iv_a}, 33'd0);
        rd(12'h008, 2'd2);  chk("R1 class/rev", {1'b0, r_a}, {1'b0, 32'h0604_00A5});
        chk("R11 read latency", lat, 2);
        rd(12'h00C, 2'd2);  chk("R1 header/cache line", {1'b0, r_a}, {1'b0, 32'h0001_0010});
        rd(12'h004, 2'd2);  chk("R1 command reset", {1'b0, r_a}, 33'd0);
        wr(12'h008, 2'd2, 32'h0);
        chk("R11 write latency", lat, 3);
        rd(12'h008, 2'd2);  chk("R1 class ignores write", {1'b0, r_a}, {1'b0, 32'h0604_00A5});

        // R2 identity
        rd(12'h000, 2'd2);  chk("R2 ident", {1'b0, r_a}, {1'b0, 32'hBEEF_C0DE});
        rd(12'h002, 2'd0);  chk("R5 ident byte lane 2", {1'b0, r_a}, {1'b0, 32'h0000_00EF});

        // R4 zero and unsupported offsets
        rd(12'h024, 2'd2);  chk("R4 pref zero", {e_a, r_a}, 33'd0);
        rd(12'h038, 2'd2);  chk("R4 rom zero", {e_a, r_a}, 33'd0);
        rd(12'h03C, 2'd2);  chk("R4 irq zero", {e_a, r_a}, 33'd0);
        rd(12'h028, 2'd2);  chk("R4 0x28 error", {e_a, r_a}, {1'b1, 32'hFFFF_FFFF});
        rd(12'h034, 2'd2);  chk("R4 0x34 error", {e_a, r_a}, {1'b1, 32'hFFFF_FFFF});
        rd(12'h040, 2'd2);  chk("R4 0x40 error", {e_a, r_a}, {1'b1, 32'hFFFF_FFFF});
        rd(12'h100, 2'd2);  chk("R4 0x100 error", {e_a, r_a}, {1'b1, 32'hFFFF_FFFF});

        // R5 lane merge and extract sweep on BAR0
        wr(12'h010, 2'd2, 32'h0);
        bar = 32'h0;
        for (int lane = 0; lane < 4; lane++) begin
            logic [7:0] v;
            v = 8'(8'h11 * (lane + 1));
            wr(12'h010 + AW'(lane), 2'd0, {24'hFFFFFF, v});
            bar[lane*8 +: 8] = v;
            rd(12'h010, 2'd2);
            chk("R5 byte merge", {1'b0, r_a}, {1'b0, bar});
        end
        for (int lane = 0; lane < 4; lane++) begin
            rd(12'h010 + AW'(lane), 2'd0);
            chk("R5 byte extract", {1'b0, r_a}, {25'h0, bar[lane*8 +: 8]});
        end
        wr(12'h012, 2'd1, 32'hFFFF_ABCD);
        bar[31:16] = 16'hABCD;
        rd(12'h010, 2'd2);  chk("R5 half merge", {1'b0, r_a}, {1'b0, bar});
        rd(12'h012, 2'd1);  chk("R5 half extract", {1'b0, r_a}, {17'h0, 16'hABCD});
        wr(12'h014, 2'd2, 32'h5A5A_0F0F);
        rd(12'h014, 2'd2);  chk("R5 word bar1", {1'b0, r_a}, {1'b0, 32'h5A5A_0F0F});

        // R12 bad size
        wr(12'h010, 2'd3, 32'h0);
        chk("R12 bad size err", {32'h0, e_a}, 33'd1);
        rd(12'h010, 2'd2);  chk("R12 no store", {1'b0, r_a}, {1'b0, bar});
        rd(12'h010, 2'd3);  chk("R12 bad size read", {e_a, r_a}, {1'b1, 32'hFFFF_FFFF});

        // R9 bus numbers
        wr(12'h018, 2'd2, 32'h4007_0501);
        chk("R9 bus strobe", {32'h0, c_bus}, 33'd1);
        chk("R9 sec bus out", {25'h0, sb_a}, {25'h0, 8'h05});
        rd(12'h018, 2'd2);  chk("R9 bus readback", {1'b0, r_a}, {1'b0, 32'h4007_0501});
        chk("R9 no strobe on read", {32'h0, c_bus}, 33'd0);
        wr(12'h01A, 2'd0, 32'h0000_0009);
        chk("R9 strobe on byte write", {32'h0, c_bus}, 33'd1);
        rd(12'h018, 2'd2);  chk("R9 subordinate byte", {1'b0, r_a}, {1'b0, 32'h4009_0501});

        // R10/R7 memory enable then sweep
        wr(12'h004, 2'd2, 32'h0000_0002);
        chk("R10 mem toggle strobe", {31'h0, c_mem, c_io}, 33'b10);
        @(negedge clk);
        chk("R10 strobe one cycle", {32'h0, mc_a}, 33'd0);
        for (int bi = 0; bi < 4; bi++) begin
            for (int li = 0; li < 4; li++) begin
                logic [15:0] mb, ml;
                logic [32:0] eb, el;
                logic        ev;
                mb = mlist[bi];
                ml = mlist[li] | 16'(li);
                wr(12'h020, 2'd2, {ml, mb});
                chk("R10 mem write strobe", {32'h0, c_mem}, 33'd1);
                ev = (ml >= mb);
                eb = {1'b0, mb[15:4], 20'h0};
                el = {1'b0, ml[15:4], 20'hFFFFF};
                chk("R7 mem valid", {32'h0, mv_a}, {32'h0, ev});
                chk("R7 mem base", {1'b0, mb_a}, ev ? eb : 33'd0);
                chk("R7 mem size", ms_a, ev ? (el - eb + 33'd1) : 33'd0);
            end
        end
        wr(12'h020, 2'd2, 32'h00F0_0010);
        wr(12'h004, 2'd2, 32'h0000_0000);
        chk("R7 mem disabled", {32'h0, mv_a}, 33'd0);
        chk("R10 mem disable strobe", {32'h0, c_mem}, 33'd1);

        // R10 io-only toggle, R6 masking on the no-I/O instance
        wr(12'h004, 2'd2, 32'h0000_0003);
        chk("R10 both enables set", {31'h0, c_mem, c_io}, 33'b11);
        chk("R6 noio no io strobe", {32'h0, c_io_b}, 33'd0);
        rd(12'h004, 2'd2);
        chk("R6 noio cmd bit0 cleared", {1'b0, r_b}, {1'b0, 32'h0000_0002});
        chk("R1 cmd readback", {1'b0, r_a}, {1'b0, 32'h0000_0003});
        wr(12'h004, 2'd2, 32'h0000_0002);
        chk("R10 io only toggle", {31'h0, c_mem, c_io}, 33'b01);
        wr(12'h004, 2'd2, 32'h0000_0003);
        chk("R10 io only toggle back", {31'h0, c_mem, c_io}, 33'b01);

        // R8/R3 I/O sweep
        for (int bi = 0; bi < 3; bi++) begin
            for (int li = 0; li < 3; li++) begin
                for (int ub = 0; ub < 2; ub++) begin
                    for (int ul = 0; ul < 2; ul++) begin
                        logic [7:0]  sb8, sl8;
                        logic [32:0] eb, el;
                        logic        ev;
                        wr(12'h01C, 2'd2, {16'hFFFF, llist[li], blist[bi]});
                        chk("R10 io write strobe", {32'h0, c_io}, 33'd1);
                        wr(12'h030, 2'd2, {ulist[ul], ulist[ub]});
                        sb8 = blist[bi] | 8'h01;
                        sl8 = llist[li] | 8'h01;
                        rd(12'h01C, 2'd2);
                        chk("R3 io type code and status", {1'b0, r_a}, {17'h0, sl8, sb8});
                        chk("R6 noio io dword", {1'b0, r_b}, 33'd0);
                        ev = !(sl8 < sb8) && !(ulist[ul] < ulist[ub]);
                        eb = {1'b0, ulist[ub], sb8[7:4], 12'h000};
                        el = {1'b0, ulist[ul], sl8[7:4], 12'hFFF};
                        chk("R8 io valid", {32'h0, iv_a}, {32'h0, ev});
                        chk("R8 io base", {1'b0, ib_a}, ev ? eb : 33'd0);
                        chk("R8 io size", is_a, ev ? (el - eb + 33'd1) : 33'd0);
                        chk("R6 noio io invalid", {32'h0, iv_b}, 33'd0);
                    end
                end
            end
        end
        rd(12'h030, 2'd2);
        chk("R6 noio upper io readable", {1'b0, r_b}, {1'b0, 32'h0001_0001});

        // R10 both strobes in one cycle, then no change
        wr(12'h020, 2'd2, 32'h0010_0010);
        chk("R7 mem valid before drop", {32'h0, mv_a}, 33'd1);
        wr(12'h004, 2'd2, 32'h0000_0000);
        chk("R10 dual strobe", {31'h0, c_mem, c_io}, 33'b11);
        chk("R7 R8 windows dropped", {31'h0, mv_a, iv_a}, 33'd0);
        wr(12'h004, 2'd2, 32'h0000_0000);
        chk("R10 no toggle no strobe", {31'h0, c_mem, c_io}, 33'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule